// File: doc/BRIEF.md
# Six-State Hardwired Control Sequencer

This block is the control unit of a small accumulator machine. It takes the 4-bit operation code held in the instruction register. It steps a one-hot timing ring through six states, T1 to T6. On every cycle it produces a 12-bit control word that drives the program counter, memory address register, RAM, instruction register, accumulator, ALU, B register and output register. The block holds no datapath state of its own. It only decides which unit drives the shared bus and which units load from it.

The first three states fetch an instruction and are the same for every opcode. The last three states execute it. Some control lines are active-high and others are active-low, so the word with nothing active is 12'h3E3. When the halt opcode is seen in T4, a sticky halt flag is raised. The ring then stays in T4 with an idle word until clear is asserted.

Top module: `seq_ctrl_unit`

## Requirements
- R1: While `clr` is high the ring is in T1 (`tstate` = 6'b000001), `halted` is 0 and `ctrl` is 12'h5E3. Clear acts at once, without waiting for a clock edge, and from any state.
- R2: When not halted, `tstate` is one-hot, with bit k meaning T(k+1). It moves one bit higher on each rising clock edge and returns from T6 to T1.
- R3: `ctrl` bits 11..0 are, in order: PC increment, PC bus enable, MAR load (low), RAM bus enable (low), IR load (low), IR bus enable (low), ACC load (low), ACC bus enable, subtract select, ALU bus enable, B load (low), output load (low). For every opcode the fetch words are 12'h5E3 in T1, 12'hBE3 in T2 and 12'h263 in T3.
- R4: For load (opcode 4'h0), the words for T4, T5 and T6 are 12'h1A3, 12'h2C3 and 12'h3E3.
- R5: For add (opcode 4'h1), the words for T4, T5 and T6 are 12'h1A3, 12'h2E1 and 12'h3C7.
- R6: For subtract (opcode 4'h2), the words for T4, T5 and T6 are 12'h1A3, 12'h2E1 and 12'h3CF. This is the add sequence with the subtract select set in T6 only.
- R7: For output (opcode 4'hE), the words for T4, T5 and T6 are 12'h3F2, 12'h3E3 and 12'h3E3.
- R8: For halt (opcode 4'hF), `ctrl` is 12'h3E3 in T4 and `halted` is 0. From the next edge on, `halted` is 1, `tstate` stays at T4 and `ctrl` stays 12'h3E3, whatever the opcode does, until `clr` is asserted.
- R9: Any other opcode gives 12'h3E3 in T4, T5 and T6, and the ring keeps cycling.
- R10: At most one of the five bus drivers is enabled in any cycle: PC, RAM, IR, ACC or ALU.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Asynchronous active-high clear |
| opcode | input | 4 | Operation code from the instruction register |
| ctrl | output | 12 | Mixed-polarity control word |
| tstate | output | 6 | One-hot timing state, bit 0 = T1 |
| halted | output | 1 | Sticky halt flag |

## Verification
The assertions assume that `opcode` holds the current instruction from T4 through T6. In the real machine the instruction register is loaded in T3 and does not change afterwards. The halt rule makes one exception: the opcode may change freely once the flag is set. The stimulus therefore changes the opcode only while the ring is in T1, or while the block is halted. After halting, the bench moves the opcode on purpose to show that the change has no effect.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int NUM_T   = 6;
    localparam int OPC_W   = 4;
    localparam int CW_W    = 12;

    // ring positions (bit index in one-hot vector)
    localparam int T1_IX = 0;
    localparam int T2_IX = 1;
    localparam int T3_IX = 2;
    localparam int T4_IX = 3;
    localparam int T5_IX = 4;
    localparam int T6_IX = 5;

    localparam logic [OPC_W-1:0] OP_LOAD = 4'h0;
    localparam logic [OPC_W-1:0] OP_ADD  = 4'h1;
    localparam logic [OPC_W-1:0] OP_SUB  = 4'h2;
    localparam logic [OPC_W-1:0] OP_OUT  = 4'hE;
    localparam logic [OPC_W-1:0] OP_HALT = 4'hF;

    typedef struct packed {
        logic pc_inc;
        logic pc_drv;
        logic mar_ld_n;
        logic ram_drv_n;
        logic ir_ld_n;
        logic ir_drv_n;
        logic acc_ld_n;
        logic acc_drv;
        logic alu_sub;
        logic alu_drv;
        logic b_ld_n;
        logic out_ld_n;
    } cword_t;

    localparam cword_t CW_IDLE = '{
        pc_inc: 1'b0, pc_drv: 1'b0, mar_ld_n: 1'b1, ram_drv_n: 1'b1,
        ir_ld_n: 1'b1, ir_drv_n: 1'b1, acc_ld_n: 1'b1, acc_drv: 1'b0,
        alu_sub: 1'b0, alu_drv: 1'b0, b_ld_n: 1'b1, out_ld_n: 1'b1
    };

endpackage

// File: rtl/seq_state_ring.sv
module seq_state_ring
    import seq_pkg::*;
#(
    parameter int N = NUM_T
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         halt_req,
    output logic [N-1:0] state,
    output logic         halted
);

    typedef struct packed {
        logic [N-1:0] ring;
        logic         halt;
    } ring_regs_t;

    ring_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.halt = r_q.halt | halt_req;
        if (!r_d.halt) begin
            r_d.ring = {r_q.ring[N-2:0], r_q.ring[N-1]};
        end
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            r_q.ring <= N'(1);
            r_q.halt <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state  = r_q.ring;
    assign halted = r_q.halt;

    // R2
    ring_onehot_chk: assert property (@(posedge clk) disable iff (clr)
        $countones(state) == 1);

    // R2
    ring_step_chk: assert property (@(posedge clk) disable iff (clr)
        (!halted && !halt_req) |=> (state == {$past(state[N-2:0]), $past(state[N-1])}));

    // R8
    halt_freeze_chk: assert property (@(posedge clk) disable iff (clr)
        halted |=> (halted && $stable(state)));

    // R8
    halt_cause_chk: assert property (@(posedge clk) disable iff (clr)
        $rose(halted) |-> $past(halt_req));

endmodule

// File: rtl/seq_word_decode.sv
module seq_word_decode
    import seq_pkg::*;
(
    input  logic [NUM_T-1:0] state,
    input  logic [OPC_W-1:0] opcode,
    input  logic             halted,
    output cword_t           word,
    output logic             halt_req
);

    logic is_load, is_add, is_sub, is_out, is_halt, is_arith;

    always_comb begin
        is_load  = (opcode == OP_LOAD);
        is_add   = (opcode == OP_ADD);
        is_sub   = (opcode == OP_SUB);
        is_out   = (opcode == OP_OUT);
        is_halt  = (opcode == OP_HALT);
        is_arith = is_add | is_sub;
    end

    always_comb begin
        word     = CW_IDLE;
        halt_req = 1'b0;
        if (halted) begin
            word = CW_IDLE;
        end else if (state[T1_IX]) begin
            word.pc_drv   = 1'b1;
            word.mar_ld_n = 1'b0;
        end else if (state[T2_IX]) begin
            word.pc_inc = 1'b1;
        end else if (state[T3_IX]) begin
            word.ram_drv_n = 1'b0;
            word.ir_ld_n   = 1'b0;
        end else if (state[T4_IX]) begin
            if (is_load | is_arith) begin
                word.ir_drv_n = 1'b0;
                word.mar_ld_n = 1'b0;
            end else if (is_out) begin
                word.acc_drv  = 1'b1;
                word.out_ld_n = 1'b0;
            end else if (is_halt) begin
                halt_req = 1'b1;
            end
        end else if (state[T5_IX]) begin
            if (is_load) begin
                word.ram_drv_n = 1'b0;
                word.acc_ld_n  = 1'b0;
            end else if (is_arith) begin
                word.ram_drv_n = 1'b0;
                word.b_ld_n    = 1'b0;
            end
        end else if (state[T6_IX]) begin
            if (is_arith) begin
                word.alu_drv  = 1'b1;
                word.alu_sub  = is_sub;
                word.acc_ld_n = 1'b0;
            end
        end
    end

endmodule

// File: rtl/seq_ctrl_unit.sv
module seq_ctrl_unit
    import seq_pkg::*;
(
    input  logic                  clk,
    input  logic                  clr,
    input  logic [OPC_W-1:0]      opcode,
    output logic [CW_W-1:0]       ctrl,
    output logic [NUM_T-1:0]      tstate,
    output logic                  halted
);

    cword_t           word;
    logic             halt_req;
    logic [NUM_T-1:0] ring;
    logic             halt_flag;

    seq_state_ring #(.N(NUM_T)) ring_i (
        .clk      (clk),
        .clr      (clr),
        .halt_req (halt_req),
        .state    (ring),
        .halted   (halt_flag)
    );

    seq_word_decode decode_i (
        .state    (ring),
        .opcode   (opcode),
        .halted   (halt_flag),
        .word     (word),
        .halt_req (halt_req)
    );

    assign ctrl   = word;
    assign tstate = ring;
    assign halted = halt_flag;

    logic [4:0] bus_drivers;
    assign bus_drivers = {word.pc_drv, ~word.ram_drv_n, ~word.ir_drv_n,
                          word.acc_drv, word.alu_drv};

    // R10
    one_driver_chk: assert property (@(posedge clk) disable iff (clr)
        $countones(bus_drivers) <= 1);

    // R3
    fetch_t1_chk: assert property (@(posedge clk) disable iff (clr)
        (tstate[T1_IX] && !halted) |-> (ctrl == 12'h5E3));

    // R3
    fetch_t3_chk: assert property (@(posedge clk) disable iff (clr)
        (tstate[T3_IX] && !halted) |-> (ctrl == 12'h263));

    // R8
    halted_idle_chk: assert property (@(posedge clk) disable iff (clr)
        halted |-> (ctrl == 12'h3E3 && tstate[T4_IX]));

endmodule

// File: tb/seq_ctrl_unit_tb_top.sv
module seq_ctrl_unit_tb_top;

    logic        clk = 1'b0;
    logic        clr = 1'b1;
    logic [3:0]  opcode = 4'h0;
    logic [11:0] ctrl;
    logic [5:0]  tstate;
    logic        halted;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    seq_ctrl_unit dut_i (
        .clk    (clk),
        .clr    (clr),
        .opcode (opcode),
        .ctrl   (ctrl),
        .tstate (tstate),
        .halted (halted)
    );

    typedef struct packed {
        logic [3:0]        op;
        logic [5:0][11:0]  w;   // w[0] = T1 ... w[5] = T6
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{4'h0, {12'h3E3, 12'h2C3, 12'h1A3, 12'h263, 12'hBE3, 12'h5E3}}, // R4
        '{4'h1, {12'h3C7, 12'h2E1, 12'h1A3, 12'h263, 12'hBE3, 12'h5E3}}, // R5
        '{4'h2, {12'h3CF, 12'h2E1, 12'h1A3, 12'h263, 12'hBE3, 12'h5E3}}, // R6
        '{4'hE, {12'h3E3, 12'h3E3, 12'h3F2, 12'h263, 12'hBE3, 12'h5E3}}, // R7
        '{4'h3, {12'h3E3, 12'h3E3, 12'h3E3, 12'h263, 12'hBE3, 12'h5E3}}, // R9
        '{4'h7, {12'h3E3, 12'h3E3, 12'h3E3, 12'h263, 12'hBE3, 12'h5E3}}, // R9
        '{4'hD, {12'h3E3, 12'h3E3, 12'h3E3, 12'h263, 12'hBE3, 12'h5E3}}  // R9
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 tstate", 32'(tstate), 32'h01);
        check("R1 halted", 32'(halted), 32'h0);
        check("R1 ctrl",   32'(ctrl),   32'h5E3);
        clr = 1'b0;

        // table walk: R2..R7, R9
        for (int v = 0; v < NV; v++) begin
            opcode = VEC[v].op;
            for (int k = 0; k < 6; k++) begin
                check("R2 tstate", 32'(tstate), 32'(6'b1 << k));
                check(k < 3 ? "R3 fetch word" : "R4-R7/R9 exec word",
                      32'(ctrl), 32'(VEC[v].w[k]));
                @(negedge clk);
            end
        end
        // R2 wrap back to T1
        check("R2 wrap", 32'(tstate), 32'h01);

        // R8 halt
        opcode = 4'hF;
        for (int k = 0; k < 3; k++) @(negedge clk);
        check("R8 T4 tstate", 32'(tstate), 32'h08);
        check("R8 T4 ctrl",   32'(ctrl),   32'h3E3);
        check("R8 T4 not yet halted", 32'(halted), 32'h0);
        @(negedge clk);
        check("R8 halted", 32'(halted), 32'h1);
        check("R8 frozen tstate", 32'(tstate), 32'h08);
        opcode = 4'h1;
        repeat (5) @(negedge clk);
        check("R8 still halted", 32'(halted), 32'h1);
        check("R8 ignore opcode tstate", 32'(tstate), 32'h08);
        check("R8 ignore opcode ctrl",   32'(ctrl),   32'h3E3);

        // R1 clear releases halt
        clr = 1'b1;
        #1;
        check("R1 clear tstate", 32'(tstate), 32'h01);
        check("R1 clear halted", 32'(halted), 32'h0);
        @(negedge clk);
        clr = 1'b0;
        opcode = 4'h0;
        for (int k = 0; k < 4; k++) begin
            check("R4 restart word", 32'(ctrl), 32'(VEC[0].w[k]));
            @(negedge clk);
        end

        // R1 clear mid-instruction (now in T5 of a load)
        check("R1 mid T5", 32'(tstate), 32'h10);
        clr = 1'b1;
        #1;
        check("R1 mid clear tstate", 32'(tstate), 32'h01);
        check("R1 mid clear ctrl",   32'(ctrl),   32'h5E3);
        @(negedge clk);
        clr = 1'b0;

        // R10 bus driver exclusivity across a subtract instruction
        opcode = 4'h2;
        for (int k = 0; k < 6; k++) begin
            check("R10 one driver",
                  32'($countones({ctrl[10], ~ctrl[8], ~ctrl[6], ctrl[4], ctrl[2]}) <= 1),
                  32'h1);
            @(negedge clk);
        end

        done = 1'b1;
        summary();
    end

endmodule